// File: doc/BRIEF.md
# Multi-Dimensional Element Index Remapper

This block turns the linear element counter of a vector loop into a reshaped element index. The elements are viewed as an array of up to three axes with sizes `lim_x`, `lim_y` and `lim_z`. Three axis counters advance together as one nested counter. A programmable order picks which axis moves fastest and which axes take its carries. Before the first element is produced the counters are advanced a programmable number of steps, so the walk begins partway into the array. Axes below a threshold can be masked to zero, and any axis can be mirrored against its size. The surviving axis values fold to one linear index, `x + y*lim_x + z*lim_x*lim_y`.

A `start` pulse samples the whole configuration. The block then replays the pre-skip steps and, for a resumed loop, the steps up to a saved element position. It replays one step per clock with `busy` high. After that it presents one index per element with `valid` high. Each `step` accepted while `valid` is high moves on to the next element. When the element number reaches the vector length the run ends. A vector length larger than the array size makes the index pattern repeat. This lets a loop that was interrupted restart at the element it stopped on.

Top module: `idx_remap`

## Requirements
- R1: After reset, `busy` and `valid` are 0, and `idx_out` and `elem_out` are 0. While the block is idle and no `start` is seen, `valid` stays 0.
- R2: A `start` sampled at a rising edge makes `busy` 1 and `valid` 0 after that edge. All configuration inputs are sampled only at that edge, and later changes to them have no effect on the run.
- R3: After the `start` edge, `busy` stays 1 for exactly `skip + resume_pos + 1` cycles. At the edge that clears `busy`, `valid` becomes 1 if `resume_pos < vlen`. `busy` and `valid` are never both 1.
- R4: One step advances the axis named by `ord_first` (0 = x, 1 = y, 2 = z). An axis that reaches its size returns to 0 and carries into the axis named by `ord_mid`, and from there into `ord_last`. With x=4, y=4 and y moving fastest, the indices are 0,4,8,12,1,5,...
- R5: `idx_out` equals `tx + ty*lim_x + tz*lim_x*lim_y`, where t is each axis value after masking and mirroring. With the identity order and no skip, mirroring or masking, the sequence is 0,1,2,...
- R6: Before element 0, the counters are advanced `skip` steps by the R4 rule.
- R7: Every axis whose number (x=0, y=1, z=2) is below `mask_below` contributes 0. With `mask_below` = 3, `idx_out` is 0.
- R8: When bit a of `mirror` is set (bit 0 = x, bit 1 = y, bit 2 = z), an unmasked axis a contributes `lim_a - 1 - count_a`.
- R9: Each `step` seen at an edge while `valid` is 1 increments `elem_out` and advances the counters one step. `valid` falls after the step that takes `elem_out` to `vlen`. If `vlen` is larger than the array size, the indices repeat cyclically.
- R10: `elem_out` starts at `resume_pos`, and every index equals the one that element would have in an uninterrupted run. If `resume_pos >= vlen`, `valid` never rises.
- R11: While `valid` is 1 and `step` is 0, `idx_out`, `elem_out` and `valid` hold.
- R12: An axis size of 0 acts as 1. `idx_out` is the folded value modulo 2^`DIM_W`.
- R13: A `start` during a replay or a run abandons it and begins the new run as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample configuration and begin a run |
| step | input | 1 | Advance to the next element while `valid` |
| lim_x | input | DIM_W | Size of axis x |
| lim_y | input | DIM_W | Size of axis y |
| lim_z | input | DIM_W | Size of axis z |
| ord_first | input | 2 | Fastest-moving axis (0 x, 1 y, 2 z) |
| ord_mid | input | 2 | Axis taking the first carry |
| ord_last | input | 2 | Axis taking the second carry |
| skip | input | CNT_W | Pre-skip steps before element 0 |
| vlen | input | CNT_W | Vector length (element count) |
| resume_pos | input | CNT_W | Element position to resume at |
| mirror | input | 3 | Per-axis mirror flags |
| mask_below | input | 2 | Axes numbered below this contribute 0 |
| busy | output | 1 | Replay in progress |
| valid | output | 1 | `idx_out` holds the current element's index |
| idx_out | output | DIM_W | Remapped element index |
| elem_out | output | CNT_W | Current element number |

## Verification
Every output is registered or decoded from registers. A `start` is visible as `busy` one edge later. `valid` follows `skip + resume_pos + 1` edges after that. Each accepted `step` shows a new index and element number one edge after the edge that sampled it. The bench drives inputs and samples outputs on falling edges. It predicts the busy, valid and element state one edge ahead, using the same edge counts, and derives each expected index from a from-scratch walk of that element's position. Random gaps in `step` test the hold behaviour, and the configuration inputs are scrambled after every `start`.

// File: rtl/remap_pkg.sv
package remap_pkg;
   localparam int NUM_AX = 3;
   typedef logic [1:0] ax_sel_t;
   localparam ax_sel_t AX_X = 2'd0;
   localparam ax_sel_t AX_Y = 2'd1;
   localparam ax_sel_t AX_Z = 2'd2;
endpackage

// File: rtl/remap_carry.sv
// Next value of the nested axis counters under a programmable carry order.
module remap_carry
   import remap_pkg::*;
#(
   parameter int DIM_W = 7
) (
   input  logic [NUM_AX-1:0][DIM_W-1:0] cnt,
   input  logic [NUM_AX-1:0][DIM_W-1:0] lim,
   input  ax_sel_t [NUM_AX-1:0]         ord,
   output logic [NUM_AX-1:0][DIM_W-1:0] nxt
);
   always_comb begin
      logic carry;
      ax_sel_t a;
      nxt   = cnt;
      carry = 1'b1;
      a     = AX_X;
      for (int k = 0; k < NUM_AX; k++) begin
         if (carry) begin
            a = ord[k];
            if (({1'b0, cnt[a]} + 1'b1) >= {1'b0, lim[a]}) begin
               nxt[a] = '0;
            end else begin
               nxt[a] = cnt[a] + 1'b1;
               carry  = 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/remap_mul.sv
// Registered product of the two lower axis sizes (plane stride).
module remap_mul #(
   parameter int DIM_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIM_W-1:0]   a,
   input  logic [DIM_W-1:0]   b,
   output logic [2*DIM_W-1:0] p
);
   always_ff @(posedge clk) begin
      if (!rst_n) p <= '0;
      else        p <= (2*DIM_W)'(a) * (2*DIM_W)'(b);
   end
endmodule

// File: rtl/remap_fold.sv
// Mask, mirror and fold the axis counters into one linear index.
module remap_fold
   import remap_pkg::*;
#(
   parameter int DIM_W = 7
) (
   input  logic [NUM_AX-1:0][DIM_W-1:0] cnt,
   input  logic [NUM_AX-1:0][DIM_W-1:0] lim,
   input  logic [NUM_AX-1:0]            mirror,
   input  logic [1:0]                   mask,
   input  logic [2*DIM_W-1:0]           plane,
   output logic [DIM_W-1:0]             idx
);
   localparam int SUM_W = 4 * DIM_W;

   logic [NUM_AX-1:0][DIM_W-1:0] term;
   logic [SUM_W-1:0]             sum;

   for (genvar g = 0; g < NUM_AX; g++) begin : g_axis
      assign term[g] = (mask > 2'(g)) ? '0 :
                       mirror[g]      ? (lim[g] - cnt[g] - 1'b1) :
                                        cnt[g];
   end

   assign sum = SUM_W'(term[0])
              + SUM_W'(term[1]) * SUM_W'(lim[0])
              + SUM_W'(term[2]) * SUM_W'(plane);
   assign idx = sum[DIM_W-1:0];
endmodule

// File: rtl/idx_remap.sv
module idx_remap
   import remap_pkg::*;
#(
   parameter int DIM_W = 7,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             step,
   input  logic [DIM_W-1:0] lim_x,
   input  logic [DIM_W-1:0] lim_y,
   input  logic [DIM_W-1:0] lim_z,
   input  logic [1:0]       ord_first,
   input  logic [1:0]       ord_mid,
   input  logic [1:0]       ord_last,
   input  logic [CNT_W-1:0] skip,
   input  logic [CNT_W-1:0] vlen,
   input  logic [CNT_W-1:0] resume_pos,
   input  logic [2:0]       mirror,
   input  logic [1:0]       mask_below,
   output logic             busy,
   output logic             valid,
   output logic [DIM_W-1:0] idx_out,
   output logic [CNT_W-1:0] elem_out
);
   localparam int REM_W = CNT_W + 1;

   if (DIM_W < 2 || DIM_W > 16) begin : g_bad_dim
      $error("idx_remap: DIM_W must lie in 2..16");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("idx_remap: CNT_W must be at least 2");
   end

   logic [NUM_AX-1:0][DIM_W-1:0] lim_in;
   logic [NUM_AX-1:0][DIM_W-1:0] cfg_lim;
   ax_sel_t [NUM_AX-1:0]         cfg_ord;
   logic [NUM_AX-1:0]            cfg_mirror;
   logic [1:0]                   cfg_mask;
   logic [CNT_W-1:0]             cfg_vlen;
   logic [NUM_AX-1:0][DIM_W-1:0] cnt_q;
   logic [NUM_AX-1:0][DIM_W-1:0] cnt_nxt;
   logic [REM_W-1:0]             rem_q;
   logic [CNT_W-1:0]             elem_q;
   logic [2*DIM_W-1:0]           plane;
   logic                         busy_q;
   logic                         valid_q;
   logic [CNT_W:0]               elem_inc;

   assign lim_in[0] = lim_x;
   assign lim_in[1] = lim_y;
   assign lim_in[2] = lim_z;
   assign elem_inc  = {1'b0, elem_q} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_ord    <= {AX_Z, AX_Y, AX_X};
         cfg_mirror <= '0;
         cfg_mask   <= '0;
         cfg_vlen   <= '0;
      end else if (start) begin
         cfg_ord    <= {ord_last, ord_mid, ord_first};
         cfg_mirror <= mirror;
         cfg_mask   <= mask_below;
         cfg_vlen   <= vlen;
      end
   end

   for (genvar g = 0; g < NUM_AX; g++) begin : g_lim
      always_ff @(posedge clk) begin
         if (!rst_n)     cfg_lim[g] <= DIM_W'(1);
         else if (start) cfg_lim[g] <= (lim_in[g] == '0) ? DIM_W'(1) : lim_in[g];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         rem_q   <= '0;
         elem_q  <= '0;
         busy_q  <= 1'b0;
         valid_q <= 1'b0;
      end else if (start) begin
         cnt_q   <= '0;
         rem_q   <= REM_W'(skip) + REM_W'(resume_pos);
         elem_q  <= resume_pos;
         busy_q  <= 1'b1;
         valid_q <= 1'b0;
      end else if (busy_q) begin
         if (rem_q != '0) begin
            cnt_q <= cnt_nxt;
            rem_q <= rem_q - 1'b1;
         end else begin
            busy_q  <= 1'b0;
            valid_q <= (elem_q < cfg_vlen);
         end
      end else if (valid_q && step) begin
         cnt_q   <= cnt_nxt;
         elem_q  <= elem_inc[CNT_W-1:0];
         valid_q <= (elem_inc < {1'b0, cfg_vlen});
      end
   end

   remap_carry #(.DIM_W(DIM_W)) u_carry (
      .cnt (cnt_q),
      .lim (cfg_lim),
      .ord (cfg_ord),
      .nxt (cnt_nxt)
   );

   remap_mul #(.DIM_W(DIM_W)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (cfg_lim[0]),
      .b     (cfg_lim[1]),
      .p     (plane)
   );

   remap_fold #(.DIM_W(DIM_W)) u_fold (
      .cnt    (cnt_q),
      .lim    (cfg_lim),
      .mirror (cfg_mirror),
      .mask   (cfg_mask),
      .plane  (plane),
      .idx    (idx_out)
   );

   assign busy     = busy_q;
   assign valid    = valid_q;
   assign elem_out = elem_q;
endmodule

// File: rtl/remap_chk.sv
module remap_chk #(
   parameter int DIM_W = 7,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             step,
   input logic             busy,
   input logic             valid,
   input logic [DIM_W-1:0] idx_out,
   input logic [CNT_W-1:0] elem_out,
   input logic [1:0]       cfg_mask
);
   // R3
   busy_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && valid));

   // R2
   start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !valid));

   // R11
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !step && !start) |=> (valid && $stable(idx_out) && $stable(elem_out)));

   // R9
   elem_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && step && !start) |=> (elem_out == $past(elem_out) + 1'b1));

   // R7
   all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && cfg_mask == 2'd3) |-> (idx_out == '0));

   // R1
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !valid && !start) |=> !valid);
endmodule

bind idx_remap remap_chk #(.DIM_W(DIM_W), .CNT_W(CNT_W)) u_remap_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .step     (step),
   .busy     (busy),
   .valid    (valid),
   .idx_out  (idx_out),
   .elem_out (elem_out),
   .cfg_mask (cfg_mask)
);

// File: tb/test_idx_remap.sv
`timescale 1ns/1ps
module test_idx_remap;
   localparam int DW = 7;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          step = 1'b0;
   logic [DW-1:0] lim_x = '0, lim_y = '0, lim_z = '0;
   logic [1:0]    ord_first = 2'd0, ord_mid = 2'd1, ord_last = 2'd2;
   logic [CW-1:0] skip = '0, vlen = '0, resume_pos = '0;
   logic [2:0]    mirror = '0;
   logic [1:0]    mask_below = '0;
   logic          busy, valid;
   logic [DW-1:0] idx_out;
   logic [CW-1:0] elem_out;

   int vectors = 0;
   int errors  = 0;

   int c_lim[3];
   int c_ord[3];
   int c_inv[3];
   int c_off, c_ad;

   always #2 clk = ~clk;

   idx_remap #(.DIM_W(DW), .CNT_W(CW)) i_idx_remap (
      .clk(clk), .rst_n(rst_n), .start(start), .step(step),
      .lim_x(lim_x), .lim_y(lim_y), .lim_z(lim_z),
      .ord_first(ord_first), .ord_mid(ord_mid), .ord_last(ord_last),
      .skip(skip), .vlen(vlen), .resume_pos(resume_pos),
      .mirror(mirror), .mask_below(mask_below),
      .busy(busy), .valid(valid), .idx_out(idx_out), .elem_out(elem_out)
   );

   task automatic chk(string req, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int ref_idx(int k);
      int ix[3];
      int t[3];
      ix = '{0, 0, 0};
      for (int s = 0; s < c_off + k; s++) begin
         for (int p = 0; p < 3; p++) begin
            ix[c_ord[p]]++;
            if (ix[c_ord[p]] < c_lim[c_ord[p]]) break;
            ix[c_ord[p]] = 0;
         end
      end
      for (int i = 0; i < 3; i++) begin
         if (i < c_ad)          t[i] = 0;
         else if (c_inv[i] != 0) t[i] = c_lim[i] - 1 - ix[i];
         else                   t[i] = ix[i];
      end
      return (t[0] + t[1] * c_lim[0] + t[2] * c_lim[0] * c_lim[1]) % 128;
   endfunction

   task automatic run_case(string tag, int x, int y, int z, int o0, int o1, int o2,
                           int off, int inv, int ad, int vl, int res, int max_cyc);
      bit exp_busy, exp_valid, st, prev_st;
      int rem, elem;
      bit first;
      @(negedge clk);
      lim_x = DW'(x); lim_y = DW'(y); lim_z = DW'(z);
      ord_first = 2'(o0); ord_mid = 2'(o1); ord_last = 2'(o2);
      skip = CW'(off); mirror = 3'(inv); mask_below = 2'(ad);
      vlen = CW'(vl); resume_pos = CW'(res);
      start = 1'b1; step = 1'b0;
      c_lim[0] = (x == 0) ? 1 : x;
      c_lim[1] = (y == 0) ? 1 : y;
      c_lim[2] = (z == 0) ? 1 : z;
      c_ord = '{o0, o1, o2};
      c_inv = '{inv & 1, (inv >> 1) & 1, (inv >> 2) & 1};
      c_off = off; c_ad = ad;
      @(negedge clk);
      start = 1'b0;
      // R2: scramble configuration after the sampling edge
      lim_x = DW'($urandom); lim_y = DW'($urandom); lim_z = DW'($urandom);
      ord_first = 2'($urandom); ord_mid = 2'($urandom); ord_last = 2'($urandom);
      skip = CW'($urandom); vlen = CW'($urandom); resume_pos = CW'($urandom);
      mirror = 3'($urandom); mask_below = 2'($urandom);
      exp_busy = 1'b1; exp_valid = 1'b0; rem = off + res; elem = res;
      first = 1'b1; prev_st = 1'b1;
      for (int cyc = 0; cyc < max_cyc; cyc++) begin
         chk(first ? "R2" : "R3", "busy", int'(busy), int'(exp_busy));
         chk("R3", "valid", int'(valid), int'(exp_valid));
         first = 1'b0;
         if (exp_valid) begin
            chk(tag, "idx_out", int'(idx_out), ref_idx(elem));
            chk(prev_st ? "R9" : "R11", "elem_out", int'(elem_out), elem);
         end
         if (!exp_busy && !exp_valid) break;
         st = ($urandom_range(0, 3) != 0);
         step = st;
         if (exp_busy) begin
            if (rem > 0) rem--;
            else begin
               exp_busy = 1'b0;
               exp_valid = (elem < vl);
               st = 1'b1;
            end
         end else if (exp_valid && st) begin
            elem++;
            exp_valid = (elem < vl);
         end
         prev_st = st;
         @(negedge clk);
      end
      step = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R3 watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy after reset", int'(busy), 0);
      chk("R1", "valid after reset", int'(valid), 0);
      chk("R1", "idx_out after reset", int'(idx_out), 0);
      chk("R1", "elem_out after reset", int'(elem_out), 0);
      repeat (3) @(negedge clk);
      chk("R1", "valid while idle", int'(valid), 0);

      // R5: identity walk, then a cyclic run longer than the array (R9)
      run_case("R5", 3, 4, 2, 0, 1, 2, 0, 0, 0, 24, 0, 400);
      run_case("R9", 4, 1, 1, 0, 1, 2, 0, 0, 0, 11, 0, 400);
      // R4: y moves fastest on a 4x4 array, then z-y-x order on 3D
      run_case("R4", 4, 4, 1, 1, 0, 2, 0, 0, 0, 16, 0, 400);
      run_case("R4", 3, 2, 3, 2, 1, 0, 0, 0, 0, 20, 0, 400);
      // R6: pre-skip
      run_case("R6", 3, 4, 1, 0, 1, 2, 2, 0, 0, 12, 0, 400);
      // R7: masking below y, and everything masked
      run_case("R7", 3, 3, 2, 0, 1, 2, 0, 0, 1, 18, 0, 400);
      run_case("R7", 3, 3, 2, 1, 2, 0, 1, 0, 3, 9, 0, 400);
      // R8: mirroring
      run_case("R8", 4, 3, 2, 0, 1, 2, 0, 3'b101, 0, 24, 0, 400);
      run_case("R8", 2, 5, 1, 1, 0, 2, 3, 3'b010, 0, 15, 0, 400);
      // R10: resume at saved element, and resume past the end
      run_case("R10", 3, 4, 2, 2, 0, 1, 1, 3'b001, 0, 20, 7, 400);
      run_case("R10", 3, 4, 1, 0, 1, 2, 0, 0, 0, 5, 5, 400);
      // R12: zero size acts as one; large index wraps modulo 128
      run_case("R12", 0, 5, 3, 0, 1, 2, 0, 0, 0, 16, 0, 400);
      run_case("R12", 20, 10, 2, 2, 1, 0, 0, 3'b100, 0, 40, 0, 400);
      // R13: abandon a run partway, restart with new settings
      run_case("R13", 5, 5, 1, 0, 1, 2, 4, 0, 0, 25, 0, 8);
      run_case("R13", 2, 3, 2, 1, 0, 2, 1, 3'b011, 0, 14, 2, 400);

      repeat (4) @(negedge clk);
      chk("R1", "valid after runs", int'(valid), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule